// File: doc/BRIEF.md
# Port Change Event Status Bank

This block collects state-change events from a multiport repeater and holds them until a processor reads them. It watches the partition state of each twisted-pair port and of the attachment-unit port, the link-test state of each twisted-pair port, and the loopback behaviour of the attachment-unit port while it transmits. A transition in either direction on a watched state input sets a sticky bit. A packet sent on the attachment-unit port that gets no echo on the receive pair also sets a sticky bit.

The processor first writes a page number to the command byte register. Page 1 selects this bank. It then reads one register at a time by index. Each read returns the latched bits and clears them in the same step. An event that arrives in the same cycle as the read that clears its register stays latched, so it is reported by the next read.

Top module: `prc_status_bank`

## Requirements
- R1: Reads return data only while the last byte written to the command port is 0x01. With any other page the read returns 0x00 and clears nothing.
- R2: Index 0 returns one bit per twisted-pair port, where bit n is port n. The bit is set when the partition input of that port changes in either direction.
- R3: Index 1 returns the attachment-unit partition-change event in bit 7. Bits 6..0 always read as 0.
- R4: Index 2 returns one bit per twisted-pair port, where bit n is port n. The bit is set when the link-test input of that port changes in either direction.
- R5: Index 3 bit 7 is set when a transmission on the attachment-unit port ends without any echo seen during it. A transmission is a high pulse on `aui_tx_i`, and an echo is `aui_echo_i` high while `aui_tx_i` is high. A transmission that was echoed sets nothing. Bits 6..0 read as 0.
- R6: Each later transmission without an echo sets the loopback-error bit again after it has been cleared.
- R7: A read of indices 0..3 in page 1 clears the register that was read. A second read then returns 0x00 if no new event has occurred.
- R8: An event that arrives in the same cycle as the read that clears its register is kept and is returned by the next read.
- R9: A read of any index above 3 in page 1 returns 0x00.
- R10: After reset every latch is clear and the page is 0x00. The previous-state samples are taken from the port inputs, so input levels that were present at reset produce no events.
- R11: `rd_data_o` and `rd_valid_o` are valid in the cycle after the cycle in which `rd_en_i` is high. At all other times `rd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Write strobe for the command byte |
| cmd_data_i | input | 8 | Page number to select |
| rd_en_i | input | 1 | Read strobe |
| rd_idx_i | input | 5 | Index of the register to read |
| rd_data_o | output | 8 | Data returned by the read |
| rd_valid_o | output | 1 | Read data is valid |
| tp_part_i | input | 8 | Partition state of each twisted-pair port |
| aui_part_i | input | 1 | Partition state of the attachment-unit port |
| tp_link_i | input | 8 | Link-test state of each twisted-pair port |
| aui_tx_i | input | 1 | High while a packet is being sent on the attachment-unit port |
| aui_echo_i | input | 1 | Activity seen on the attachment-unit receive pair |

## Verification
A bad previous-state sample shows up as a spurious or missing bit on the next read of the register that owns it. Because every read clears its register, the error is seen only once, one cycle after that read. A stuck echo flag has one of two effects: the loopback bit never sets, or a later echoed packet reports an error. The next read of index 3 shows either case. A clear that overrides a same-cycle event loses a bit, and the bench sees this only on the second read that follows. The bench therefore pairs such reads back to back.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned IDX_W     = 5;
  localparam logic [7:0]  PAGE_ID   = 8'h01;
  localparam logic [4:0]  IDX_TPART = 5'd0;
  localparam logic [4:0]  IDX_APART = 5'd1;
  localparam logic [4:0]  IDX_TLINK = 5'd2;
  localparam logic [4:0]  IDX_LBERR = 5'd3;
endpackage

// File: rtl/prc_edge_det.sv
module prc_edge_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         arm_i,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= in_i;
  end

  // before arm, prev_q is not yet a valid sample
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign chg_o[i] = arm_i & (in_i[i] ^ prev_q[i]);
  end
endmodule

// File: rtl/prc_loop_mon.sv
module prc_loop_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic tx_i,
  input  logic echo_i,
  output logic err_o
);
  logic tx_q, echo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= 1'b0;
      echo_q <= 1'b0;
    end else begin
      tx_q <= tx_i;
      if (!tx_i)          echo_q <= 1'b0;
      else if (echo_i)    echo_q <= 1'b1;
    end
  end

  // end of packet without echo
  assign err_o = arm_i & tx_q & ~tx_i & ~echo_q;
endmodule

// File: rtl/prc_sticky_reg.sv
module prc_sticky_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= set_i;   // same-cycle event survives clear
    else            q_o <= q_o | set_i;
  end
endmodule

// File: rtl/prc_status_bank.sv
module prc_status_bank
  import prc_pkg::*;
#(
  parameter int unsigned NUM_TP = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [BYTE_W-1:0] cmd_data_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  input  logic [NUM_TP-1:0] tp_part_i,
  input  logic              aui_part_i,
  input  logic [NUM_TP-1:0] tp_link_i,
  input  logic              aui_tx_i,
  input  logic              aui_echo_i
);
  localparam int unsigned PAD_W = BYTE_W - NUM_TP;

  logic [BYTE_W-1:0] page_q;
  logic              arm_q;
  logic              page_hit;
  logic [NUM_TP-1:0] tp_part_chg, tp_link_chg;
  logic              aui_part_chg, lb_err_evt;
  logic [NUM_TP-1:0] tp_part_q, tp_link_q;
  logic              aui_part_q, lb_err_q;
  logic [3:0]        clr;
  logic [BYTE_W-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      arm_q <= 1'b1;
      if (cmd_wr_i) page_q <= cmd_data_i;
    end
  end

  assign page_hit = rd_en_i && (page_q == PAGE_ID);

  for (genvar k = 0; k < 4; k++) begin : g_clr
    assign clr[k] = page_hit && (rd_idx_i == IDX_W'(k));
  end

  prc_edge_det #(.W(NUM_TP)) u_tp_part_det (
    .clk_i, .rst_ni, .arm_i(arm_q), .in_i(tp_part_i), .chg_o(tp_part_chg));
  prc_edge_det #(.W(1)) u_aui_part_det (
    .clk_i, .rst_ni, .arm_i(arm_q), .in_i(aui_part_i), .chg_o(aui_part_chg));
  prc_edge_det #(.W(NUM_TP)) u_tp_link_det (
    .clk_i, .rst_ni, .arm_i(arm_q), .in_i(tp_link_i), .chg_o(tp_link_chg));
  prc_loop_mon u_loop_mon (
    .clk_i, .rst_ni, .arm_i(arm_q), .tx_i(aui_tx_i), .echo_i(aui_echo_i),
    .err_o(lb_err_evt));

  prc_sticky_reg #(.W(NUM_TP)) u_tp_part_reg (
    .clk_i, .rst_ni, .set_i(tp_part_chg), .clr_i(clr[0]), .q_o(tp_part_q));
  prc_sticky_reg #(.W(1)) u_aui_part_reg (
    .clk_i, .rst_ni, .set_i(aui_part_chg), .clr_i(clr[1]), .q_o(aui_part_q));
  prc_sticky_reg #(.W(NUM_TP)) u_tp_link_reg (
    .clk_i, .rst_ni, .set_i(tp_link_chg), .clr_i(clr[2]), .q_o(tp_link_q));
  prc_sticky_reg #(.W(1)) u_lb_err_reg (
    .clk_i, .rst_ni, .set_i(lb_err_evt), .clr_i(clr[3]), .q_o(lb_err_q));

  always_comb begin
    rd_mux = '0;
    if (page_hit) begin
      case (rd_idx_i)
        IDX_TPART: rd_mux = {{PAD_W{1'b0}}, tp_part_q};
        IDX_APART: rd_mux = {aui_part_q, 7'b0};
        IDX_TLINK: rd_mux = {{PAD_W{1'b0}}, tp_link_q};
        IDX_LBERR: rd_mux = {lb_err_q, 7'b0};
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_data_o  <= rd_mux;
      rd_valid_o <= rd_en_i;
    end
  end
endmodule

// File: rtl/prc_status_bank_chk.sv
module prc_status_bank_chk #(
  parameter int unsigned NUM_TP = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic [4:0]        rd_idx_i,
  input logic [7:0]        rd_data_o,
  input logic              rd_valid_o,
  input logic [7:0]        page_q,
  input logic [NUM_TP-1:0] tp_part_chg,
  input logic [NUM_TP-1:0] tp_part_q
);
  assert_valid_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  assert_no_stray_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
  assert_other_page_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && page_q != 8'h01) |=> rd_data_o == 8'h00);
  assert_aui_low_bits_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_idx_i == 5'd1) |=> rd_data_o[6:0] == 7'h0);
  assert_unimpl_idx_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_idx_i > 5'd3) |=> rd_data_o == 8'h00);
  assert_clear_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && page_q == 8'h01 && rd_idx_i == 5'd0 && tp_part_chg == '0)
      |=> tp_part_q == '0);
  assert_event_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tp_part_chg != '0) |=> ((tp_part_q & $past(tp_part_chg)) == $past(tp_part_chg)));
endmodule

bind prc_status_bank prc_status_bank_chk #(.NUM_TP(NUM_TP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i),
  .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .page_q(page_q),
  .tp_part_chg(tp_part_chg), .tp_part_q(tp_part_q));

// File: tb/tb_prc_status_bank.sv
module tb_prc_status_bank;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cmd_wr_i = 1'b0;
  logic [7:0] cmd_data_i = '0;
  logic       rd_en_i = 1'b0;
  logic [4:0] rd_idx_i = '0;
  logic [7:0] rd_data_o;
  logic       rd_valid_o;
  logic [7:0] tp_part_i = 8'hA5, tp_link_i = 8'h3C;
  logic       aui_part_i = 1'b1, aui_tx_i = 1'b0, aui_echo_i = 1'b0;

  int checks = 0, fails = 0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic [7:0]  mdl [4];
  logic [7:0]  page_m = '0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prc_status_bank dut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads as results appear
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      if (exp_q.size() == 0) chk("R11 unexpected valid", 8'h1, 8'h0);
      else chk(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_page(logic [7:0] p);
    cmd_wr_i = 1'b1; cmd_data_i = p; page_m = p;
    cyc(); cmd_wr_i = 1'b0;
  endtask

  function automatic logic [7:0] take(logic [4:0] idx);
    logic [7:0] v;
    if (page_m != 8'h01 || idx > 5'd3) return 8'h00;
    v = mdl[idx]; mdl[idx] = 8'h00;
    return v;
  endfunction

  task automatic rd(logic [4:0] idx, string tag);
    rd_en_i = 1'b1; rd_idx_i = idx;
    exp_q.push_back(take(idx)); tag_q.push_back(tag);
    cyc(); rd_en_i = 1'b0;
    cyc();
  endtask

  task automatic tog_tp(logic [7:0] m);
    tp_part_i ^= m; mdl[0] |= m; cyc();
  endtask

  task automatic pkt(bit echo);
    aui_tx_i = 1'b1; cyc(2);
    aui_echo_i = echo; cyc(); aui_echo_i = 1'b0;
    cyc(); aui_tx_i = 1'b0; cyc();
    if (!echo) mdl[3] |= 8'h80;
  endtask

  initial begin
    foreach (mdl[i]) mdl[i] = '0;
    cyc(3);
    chk("R10 reset valid", {7'b0, rd_valid_o}, 8'h00);
    chk("R10 reset data", rd_data_o, 8'h00);
    rst_ni = 1'b1;
    cyc(3);
    // R1: wrong page returns zero and clears nothing
    tog_tp(8'h01);
    rd(5'd0, "R1 page0 read");
    set_page(8'h01);
    rd(5'd0, "R1 kept after page0 read");
    // R10: no spurious events from reset levels
    for (int i = 0; i < 4; i++) rd(5'(i), "R10 no spurious");
    // R2 both directions
    tog_tp(8'h88);
    rd(5'd0, "R2 tp partition");
    rd(5'd0, "R7 cleared");
    // R3
    aui_part_i = ~aui_part_i; mdl[1] |= 8'h80; cyc();
    rd(5'd1, "R3 aui partition");
    rd(5'd1, "R7 aui cleared");
    // R4
    tp_link_i ^= 8'h42; mdl[2] |= 8'h42; cyc();
    tp_link_i ^= 8'h02; mdl[2] |= 8'h02; cyc();
    rd(5'd2, "R4 link change");
    // R5
    pkt(1'b1);
    rd(5'd3, "R5 echoed packet");
    pkt(1'b0);
    rd(5'd3, "R5 no echo");
    // R6
    pkt(1'b0);
    rd(5'd3, "R6 set again");
    rd(5'd3, "R7 lb cleared");
    // R8: event in the read cycle
    tog_tp(8'h10);
    rd_en_i = 1'b1; rd_idx_i = 5'd0;
    exp_q.push_back(take(5'd0)); tag_q.push_back("R8 read with event");
    tp_part_i ^= 8'h04; mdl[0] |= 8'h04;
    cyc(); rd_en_i = 1'b0; cyc();
    rd(5'd0, "R8 event survived");
    // R9
    tog_tp(8'h20);
    rd(5'd4, "R9 idx4");
    rd(5'd31, "R9 idx31");
    rd(5'd0, "R9 real reg intact");
    // R1 other page
    tog_tp(8'h40);
    set_page(8'h02);
    rd(5'd0, "R1 page2");
    set_page(8'h01);
    rd(5'd0, "R1 back to page1");
    cyc(3);
    chk("R11 all reads answered", 8'(exp_q.size()), 8'h00);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk_i);
    if (!done) chk("watchdog", 8'h0, 8'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule